// File: doc/BRIEF.md
# Transmit descriptor ring reader

This block moves outgoing frames from memory to a byte-wide transmit stream. Software lays out a ring of 8-byte descriptors. Each descriptor holds a buffer address word and a control word. Software clears an ownership flag in every descriptor it hands over. On a start command the reader walks the ring from its current position. For each owned descriptor it fetches the buffer one 32-bit word at a time and streams the bytes out, with start-of-frame and end-of-frame markers. It then writes the control word back with the ownership flag set. Error conditions for a frame are recorded in the control word of that frame's first descriptor.

The reader stops by itself when it meets a descriptor that software still owns at a frame boundary. A halt command lets the frame in progress finish and then parks the reader. A later start resumes at the next descriptor. Memory is reached through a simple single-port interface: read data returns exactly one cycle after a read request, and a write completes in the cycle it is issued.

Top module: `txr_top`

## Requirements
- R1: While and right after reset, `busy`, `tx_valid`, `tx_abort`, `mem_rd` and `mem_wr` are low.
- R2: Descriptor k sits at ring base + 8k. The buffer address word is at offset 0 and the control word at offset 4. The buffer byte count is in control bits 10:0. Buffers are word aligned. Bytes leave in ascending address order, with byte lane 0 (bits 7:0) of each word first.
- R3: `tx_sof` marks the first byte of a frame. `tx_eof` marks the last byte of a descriptor whose control bit 15 is set. `tx_nocrc` carries bit 16 of the frame's first descriptor. While `tx_ready` is low, `tx_data` and the markers hold.
- R4: Only descriptors with control bit 31 clear are transmitted. Each consumed descriptor gets its control word written back with bit 31 set and all other bits kept. Finding bit 31 set at a frame boundary ends the run with no write, and `busy` drops.
- R5: After a descriptor with control bit 30 set, the next descriptor is read from the ring base.
- R6: Finding bit 31 set in the middle of a frame sets bit 27 in the first descriptor of that frame. It also pulses `tx_abort` for one cycle, ends the run, and leaves the read position on the descriptor that software still owns.
- R7: `mac_underrun` or `mac_retry_limit`, asserted while a frame is being handled, sets bit 28 or bit 29 respectively in the frame's first descriptor. The other descriptors of the frame get only bit 31.
- R8: `cmd_halt` while busy lets the current frame finish and then stops before the next descriptor, leaving that descriptor untouched. The next start resumes there. `cmd_halt` while idle has no effect.
- R9: `cfg_base_we` while idle loads both the ring base and the read position. While busy it is ignored.
- R10: A descriptor with byte count 0 is consumed and written back without emitting any byte.
- R11: Read data is taken from `mem_rdata` exactly one cycle after `mem_rd`. A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start pulse; acted on only while idle |
| cmd_halt | input | 1 | Halt request pulse |
| cfg_base_we | input | 1 | Ring base load strobe |
| cfg_base | input | 32 | Ring base address, 8-byte aligned |
| busy | output | 1 | High while transmission is active |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Consumer accepts the byte |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_nocrc | output | 1 | Frame asks for no CRC |
| tx_abort | output | 1 | One-cycle pulse when a frame is cut short |
| mac_underrun | input | 1 | Line side reports underrun for the current frame |
| mac_retry_limit | input | 1 | Line side reports retry limit for the current frame |

## Verification
The bench targets several corner cases, each tied to a likely design error:
- A frame spread over three descriptors with an empty middle one. A design that wrote the first descriptor back early would lose the error flags. One that mishandled the empty buffer would emit a stray byte or stall.
- A ring wrap, with a trap descriptor placed after the wrap point. If the wrap bit is ignored, the trap's bytes go out and its control word gets modified.
- A frame cut short by an owned descriptor, checked for the exhausted flag, the abort pulse, and a resume at exactly that descriptor.
- Halts and base writes issued mid-frame, and a halt issued while idle. A design that cut frames short, advanced past the halt point, or took the base write while busy would resume from the wrong descriptor or lose bytes.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 11;
  localparam int LANES    = WORD_W / 8;
  localparam int LANE_W   = $clog2(LANES);
  localparam int DESC_B   = 8;
  localparam int CTRL_OFS = 4;

  localparam int BIT_LAST  = 15;
  localparam int BIT_NOCRC = 16;
  localparam int BIT_EXH   = 27;
  localparam int BIT_UNDR  = 28;
  localparam int BIT_RTRY  = 29;
  localparam int BIT_WRAP  = 30;
  localparam int BIT_OWN   = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL_RQ, S_CTRL_RS, S_ADDR_RS,
    S_DATA_RS, S_STREAM, S_WB, S_WB_FIRST
  } txr_state_t;

  typedef struct packed {
    logic exh;
    logic undr;
    logic rtry;
  } txr_flags_t;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          base_we,
  input  logic [AW-1:0] base_in,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] base_q, base_d, ptr_q, ptr_d;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    if (idle && base_we) begin
      base_d = base_in;
      ptr_d  = base_in;
    end else if (advance) begin
      ptr_d = wrap ? base_q : ptr_q + STEP_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
    end
  end

  assign ptr = ptr_q;

  p_base_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && base_we) |=> $stable(base_q));
endmodule

// File: rtl/txr_frame_stat.sv
module txr_frame_stat
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       underrun,
  input  logic       retry,
  input  logic       exhaust,
  output txr_flags_t flags
);
  txr_flags_t fl_q, fl_d;

  always_comb begin
    fl_d = fl_q;
    if (clr) begin
      fl_d = '0;
    end else begin
      if (exhaust)         fl_d.exh  = 1'b1;
      if (en && underrun)  fl_d.undr = 1'b1;
      if (en && retry)     fl_d.rtry = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags = fl_q;

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fl_q == '0));
endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane
  import txr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] idx,
  output logic [7:0]        byte_o
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[8*g +: 8];
  end

  assign byte_o = lane[idx];
endmodule

// File: rtl/txr_top.sv
module txr_top
  import txr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_halt,
  input  logic              cfg_base_we,
  input  logic [WORD_W-1:0] cfg_base,
  output logic              busy,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_nocrc,
  output logic              tx_abort,
  input  logic              mac_underrun,
  input  logic              mac_retry_limit
);
  localparam logic [WORD_W-1:0] CTRL_V = WORD_W'(CTRL_OFS);
  localparam logic [WORD_W-1:0] LANES_V = WORD_W'(LANES);
  localparam logic [WORD_W-1:0] OWN_M = WORD_W'(1) << BIT_OWN;

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  txr_state_t        state_q, state_d;
  logic [WORD_W-1:0] cur_ctrl_q, cur_ctrl_d, first_ctrl_q, first_ctrl_d;
  logic [WORD_W-1:0] first_ptr_q, first_ptr_d, waddr_q, waddr_d, word_q, word_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [LANE_W-1:0] bidx_q, bidx_d;
  logic              in_frame_q, in_frame_d, is_first_q, is_first_d;
  logic              sent_q, sent_d, halt_q, halt_d;
  logic              ptr_adv, stat_clr, stat_exh;
  logic [WORD_W-1:0] ptr, stat_bits;
  txr_flags_t        flags;

  txr_ring_ptr #(.AW(WORD_W), .STEP(DESC_B)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .idle(state_q == S_IDLE),
    .base_we(cfg_base_we), .base_in(cfg_base),
    .advance(ptr_adv), .wrap(cur_ctrl_q[BIT_WRAP]), .ptr(ptr)
  );

  txr_frame_stat u_stat (
    .clk(clk), .rst_n(rst_i_n), .clr(stat_clr), .en(in_frame_q),
    .underrun(mac_underrun), .retry(mac_retry_limit),
    .exhaust(stat_exh), .flags(flags)
  );

  txr_byte_lane u_lane (.word(word_q), .idx(bidx_q), .byte_o(tx_data));

  always_comb begin
    stat_bits = '0;
    stat_bits[BIT_EXH]  = flags.exh;
    stat_bits[BIT_UNDR] = flags.undr;
    stat_bits[BIT_RTRY] = flags.rtry;
  end

  always_comb begin
    state_d      = state_q;
    cur_ctrl_d   = cur_ctrl_q;
    first_ctrl_d = first_ctrl_q;
    first_ptr_d  = first_ptr_q;
    waddr_d      = waddr_q;
    word_d       = word_q;
    remain_d     = remain_q;
    bidx_d       = bidx_q;
    in_frame_d   = in_frame_q;
    is_first_d   = is_first_q;
    sent_d       = sent_q;
    halt_d       = (state_q == S_IDLE) ? 1'b0 : (halt_q | cmd_halt);
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    mem_addr     = '0;
    mem_wdata    = '0;
    ptr_adv      = 1'b0;
    stat_clr     = 1'b0;
    stat_exh     = 1'b0;
    case (state_q)
      S_IDLE: if (cmd_start) state_d = S_CTRL_RQ;
      S_CTRL_RQ: begin
        if (halt_q && !in_frame_q) begin
          state_d = S_IDLE;
        end else begin
          mem_rd   = 1'b1;
          mem_addr = ptr + CTRL_V;
          state_d  = S_CTRL_RS;
        end
      end
      S_CTRL_RS: begin
        if (mem_rdata[BIT_OWN]) begin
          if (in_frame_q) begin
            stat_exh = 1'b1;
            state_d  = S_WB_FIRST;
          end else begin
            state_d = S_IDLE;
          end
        end else begin
          cur_ctrl_d = mem_rdata;
          mem_rd     = 1'b1;
          mem_addr   = ptr;
          state_d    = S_ADDR_RS;
          is_first_d = !in_frame_q;
          if (!in_frame_q) begin
            first_ptr_d  = ptr;
            first_ctrl_d = mem_rdata;
            in_frame_d   = 1'b1;
            sent_d       = 1'b0;
            stat_clr     = 1'b1;
          end
        end
      end
      S_ADDR_RS: begin
        remain_d = cur_ctrl_q[LEN_W-1:0];
        bidx_d   = '0;
        if (cur_ctrl_q[LEN_W-1:0] == '0) begin
          state_d = S_WB;
        end else begin
          mem_rd   = 1'b1;
          mem_addr = mem_rdata;
          waddr_d  = mem_rdata + LANES_V;
          state_d  = S_DATA_RS;
        end
      end
      S_DATA_RS: begin
        word_d  = mem_rdata;
        state_d = S_STREAM;
      end
      S_STREAM: begin
        if (tx_ready) begin
          remain_d = remain_q - LEN_W'(1);
          bidx_d   = bidx_q + LANE_W'(1);
          sent_d   = 1'b1;
          if (remain_q == LEN_W'(1)) begin
            state_d = S_WB;
          end else if (bidx_q == LANE_W'(LANES - 1)) begin
            mem_rd   = 1'b1;
            mem_addr = waddr_q;
            waddr_d  = waddr_q + LANES_V;
            state_d  = S_DATA_RS;
          end
        end
      end
      S_WB: begin
        ptr_adv  = 1'b1;
        mem_addr = ptr + CTRL_V;
        if (cur_ctrl_q[BIT_LAST]) begin
          mem_wr = 1'b1;
          if (is_first_q) begin
            mem_wdata  = cur_ctrl_q | OWN_M | stat_bits;
            in_frame_d = 1'b0;
            state_d    = S_CTRL_RQ;
          end else begin
            mem_wdata = cur_ctrl_q | OWN_M;
            state_d   = S_WB_FIRST;
          end
        end else begin
          mem_wr    = !is_first_q;
          mem_wdata = cur_ctrl_q | OWN_M;
          state_d   = S_CTRL_RQ;
        end
      end
      S_WB_FIRST: begin
        mem_wr     = 1'b1;
        mem_addr   = first_ptr_q + CTRL_V;
        mem_wdata  = first_ctrl_q | OWN_M | stat_bits;
        in_frame_d = 1'b0;
        state_d    = flags.exh ? S_IDLE : S_CTRL_RQ;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q      <= S_IDLE;
      cur_ctrl_q   <= '0;
      first_ctrl_q <= '0;
      first_ptr_q  <= '0;
      waddr_q      <= '0;
      word_q       <= '0;
      remain_q     <= '0;
      bidx_q       <= '0;
      in_frame_q   <= 1'b0;
      is_first_q   <= 1'b0;
      sent_q       <= 1'b0;
      halt_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      cur_ctrl_q   <= cur_ctrl_d;
      first_ctrl_q <= first_ctrl_d;
      first_ptr_q  <= first_ptr_d;
      waddr_q      <= waddr_d;
      word_q       <= word_d;
      remain_q     <= remain_d;
      bidx_q       <= bidx_d;
      in_frame_q   <= in_frame_d;
      is_first_q   <= is_first_d;
      sent_q       <= sent_d;
      halt_q       <= halt_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign tx_valid = (state_q == S_STREAM);
  assign tx_sof   = tx_valid && !sent_q;
  assign tx_eof   = tx_valid && (remain_q == LEN_W'(1)) && cur_ctrl_q[BIT_LAST];
  assign tx_nocrc = tx_valid && first_ctrl_q[BIT_NOCRC];
  assign tx_abort = (state_q == S_WB_FIRST) && flags.exh;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eof) && $stable(tx_sof)));
  p_eof_ends_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_valid && tx_ready && tx_eof) |=> !tx_valid);
  p_wb_owned_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_wr |-> mem_wdata[BIT_OWN]);
  p_abort_stops_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    tx_abort |=> !busy);
  p_one_access_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(mem_rd && mem_wr));
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_i_n |-> (!tx_valid && !mem_rd && !mem_wr));
endmodule

// File: tb/sim_txr_top.sv
module sim_txr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_halt = 1'b0, cfg_base_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        busy, mem_rd, mem_wr, tx_valid, tx_sof, tx_eof, tx_nocrc, tx_abort;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        mac_underrun = 1'b0, mac_retry_limit = 1'b0;

  always #10 clk = ~clk;

  txr_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
    .cfg_base_we(cfg_base_we), .cfg_base(cfg_base), .busy(busy),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_nocrc(tx_nocrc),
    .tx_abort(tx_abort), .mac_underrun(mac_underrun), .mac_retry_limit(mac_retry_limit)
  );

  // behavioural memory: 1 KiB, read data one cycle after request
  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
  end

  int checks = 0, errors = 0, aborts = 0;
  logic [10:0] expq [$];   // {nocrc, sof, eof, data}
  logic [7:0]  lfsr = 8'h5B;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'hA5 ^ 8'(a >> 8);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the byte stream against the reference queue
  always @(negedge clk) begin
    logic rdy;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy = lfsr[0] | lfsr[1];
    tx_ready = rdy;
    if (rst_n) begin
      if (tx_abort) aborts++;
      if (tx_valid && !busy) chk(1'b0, "R3 valid without busy", 32'(tx_valid), 32'(0));
      if (tx_valid && rdy) begin
        if (expq.size() == 0) chk(1'b0, "R4 unexpected byte", 32'({tx_nocrc, tx_sof, tx_eof, tx_data}), 32'hFFFF);
        else begin
          logic [10:0] e;
          e = expq.pop_front();
          chk({tx_nocrc, tx_sof, tx_eof, tx_data} == e, "R2/R3 stream byte",
              32'({tx_nocrc, tx_sof, tx_eof, tx_data}), 32'(e));
        end
      end
    end
  end

  task automatic put_desc(input int a, input int baddr, input logic [31:0] ctrl);
    mem[a >> 2]       <= 32'(baddr);
    mem[(a >> 2) + 1] <= ctrl;
  endtask

  task automatic exp_buf(input int baddr, input int len, input bit first, input bit last, input bit nocrc);
    for (int i = 0; i < len; i++)
      expq.push_back({nocrc, first && i == 0, last && i == len - 1, pat(baddr + i)});
  endtask

  task automatic set_base(input int b);
    @(negedge clk); cfg_base = 32'(b); cfg_base_we = 1'b1;
    @(negedge clk); cfg_base_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic run();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    wait_idle();
  endtask

  task automatic chk_ctrl(input int a, input logic [31:0] exp, input string tag);
    chk(mem[(a >> 2) + 1] == exp, tag, mem[(a >> 2) + 1], exp);
  endtask

  localparam logic [31:0] OWN = 32'h8000_0000, WRAP = 32'h4000_0000, LAST = 32'h0000_8000;
  localparam logic [31:0] NOCRC = 32'h0001_0000, EXH = 32'h0800_0000;
  localparam logic [31:0] UNDR = 32'h1000_0000, RTRY = 32'h2000_0000;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 256; w++)
      mem[w] <= (w < 128) ? OWN : {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !tx_valid && !mem_rd && !mem_wr && !tx_abort, "R1 reset state",
        32'({busy, tx_valid, mem_rd, mem_wr, tx_abort}), 32'(0));

    // single-buffer frame, no-CRC request (R2 R3 R4 R11)
    put_desc(32'h000, 32'h200, LAST | NOCRC | 32'd5);
    exp_buf(32'h200, 5, 1, 1, 1);
    run();
    chk(expq.size() == 0, "R3 frame A bytes all seen", 32'(expq.size()), 0);
    chk_ctrl(32'h000, OWN | LAST | NOCRC | 32'd5, "R4 frame A write-back");
    chk(mem[0] == 32'h200, "R4 address word kept", mem[0], 32'h200);
    chk_ctrl(32'h008, OWN, "R4 stop descriptor untouched");
    chk(!busy, "R4 busy drops", 32'(busy), 0);

    // three-buffer frame with an empty middle buffer (R9 R10 R3)
    set_base(32'h040);
    put_desc(32'h040, 32'h240, 32'd6);
    put_desc(32'h048, 32'h260, 32'd0);
    put_desc(32'h050, 32'h280, LAST | 32'd9);
    exp_buf(32'h240, 6, 1, 0, 0);
    exp_buf(32'h280, 9, 0, 1, 0);
    run();
    chk(expq.size() == 0, "R10 frame B bytes", 32'(expq.size()), 0);
    chk_ctrl(32'h040, OWN | 32'd6, "R4 frame B first");
    chk_ctrl(32'h048, OWN, "R10 empty buffer written back");
    chk_ctrl(32'h050, OWN | LAST | 32'd9, "R4 frame B last");

    // ring wrap with trap after the wrap point (R5)
    set_base(32'h080);
    put_desc(32'h080, 32'h2A0, LAST | 32'd3);
    put_desc(32'h088, 32'h2B0, LAST | WRAP | 32'd4);
    put_desc(32'h090, 32'h2B0, LAST | 32'd1);
    exp_buf(32'h2A0, 3, 1, 1, 0);
    exp_buf(32'h2B0, 4, 1, 1, 0);
    run();
    chk_ctrl(32'h090, LAST | 32'd1, "R5 trap untouched");
    chk_ctrl(32'h088, OWN | LAST | WRAP | 32'd4, "R5 wrap descriptor");
    put_desc(32'h080, 32'h300, LAST | 32'd2);
    exp_buf(32'h300, 2, 1, 1, 0);
    run();
    chk(expq.size() == 0, "R5 resumes at base", 32'(expq.size()), 0);
    chk_ctrl(32'h080, OWN | LAST | 32'd2, "R5 base reused");

    // exhausted mid-frame (R6)
    set_base(32'h0C0);
    put_desc(32'h0C0, 32'h2C0, 32'd4);
    exp_buf(32'h2C0, 4, 1, 0, 0);
    run();
    chk(expq.size() == 0, "R6 partial bytes", 32'(expq.size()), 0);
    chk_ctrl(32'h0C0, OWN | EXH | 32'd4, "R6 exhausted flag");
    chk(aborts == 1, "R6 abort pulse", 32'(aborts), 1);
    put_desc(32'h0C8, 32'h2E0, LAST | 32'd2);
    exp_buf(32'h2E0, 2, 1, 1, 0);
    run();
    chk(expq.size() == 0, "R6 resume at owned descriptor", 32'(expq.size()), 0);
    chk_ctrl(32'h0C8, OWN | LAST | 32'd2, "R6 resumed write-back");

    // line errors (R7)
    set_base(32'h100);
    put_desc(32'h100, 32'h310, 32'd8);
    put_desc(32'h108, 32'h320, LAST | 32'd3);
    exp_buf(32'h310, 8, 1, 0, 0);
    exp_buf(32'h320, 3, 0, 1, 0);
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    while (!tx_valid) @(negedge clk);
    mac_underrun = 1'b1; mac_retry_limit = 1'b1;
    @(negedge clk); mac_underrun = 1'b0; mac_retry_limit = 1'b0;
    wait_idle();
    chk_ctrl(32'h100, OWN | UNDR | RTRY | 32'd8, "R7 flags in first descriptor");
    chk_ctrl(32'h108, OWN | LAST | 32'd3, "R7 later descriptor plain");

    // halt mid-frame plus base write while busy (R8 R9)
    set_base(32'h140);
    put_desc(32'h140, 32'h330, LAST | 32'd12);
    put_desc(32'h148, 32'h350, LAST | 32'd2);
    exp_buf(32'h330, 12, 1, 1, 0);
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    while (!tx_valid) @(negedge clk);
    cmd_halt = 1'b1; cfg_base_we = 1'b1; cfg_base = 32'h000;
    @(negedge clk); cmd_halt = 1'b0; cfg_base_we = 1'b0;
    wait_idle();
    chk(expq.size() == 0, "R8 current frame completes", 32'(expq.size()), 0);
    chk_ctrl(32'h148, LAST | 32'd2, "R8 next descriptor untouched");
    @(negedge clk); cmd_halt = 1'b1;
    @(negedge clk); cmd_halt = 1'b0;
    exp_buf(32'h350, 2, 1, 1, 0);
    run();
    chk(expq.size() == 0, "R8 R9 resume after halt", 32'(expq.size()), 0);
    chk_ctrl(32'h148, OWN | LAST | 32'd2, "R8 resumed write-back");
    chk(aborts == 1, "R6 no extra aborts", 32'(aborts), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule